// File: doc/BRIEF.md
# Sequential Binary-to-BCD Converter

This block turns an unsigned binary word into packed decimal digits with the shift-and-add-3 method, spread over many clock cycles so that only one 4-bit correction cell is needed. A one-cycle start strobe captures the binary word. A control machine then repeats two steps. First it moves the combined decimal and binary register one place to the left, taking the next binary bit (MSB first) into the lowest decimal bit. Then it walks over the decimal digits one per clock and corrects each one on its own.

After the last binary bit has been moved in, the block skips the correction pass. It copies the working register to a held output and raises a completion flag for one cycle. Software-free users just pulse start, wait for the flag and read the digits. The output stays unchanged until the next conversion completes.

Top module: `bcd_seq_conv`

## Requirements
- R1: While reset is high and on the first cycle after it, `bcd_o` is all zeros and `done_o` is low.
- R2: After a conversion of value V, digit k of `bcd_o` (bits 4k+3 down to 4k, digit 0 least significant) equals floor(V / 10^k) mod 10, for every V that fits in `IN_W` bits, provided `NDIG` digits are enough to hold 2^IN_W - 1.
- R3: `done_o` rises exactly LAT = 2*IN_W + 2*NDIG*(IN_W-1) clock edges after the edge that accepts `start`.
- R4: `done_o` is high for exactly one cycle per conversion.
- R5: `bcd_o` changes only on the edge that raises `done_o`. Between conversions it holds its value.
- R6: A `start` pulse while a conversion is running is ignored. The running conversion finishes with its own value and its own timing, and no extra `done_o` follows.
- R7: A `start` given in the same cycle that `done_o` is high is accepted, and it begins a new conversion with the full latency.
- R8: A digit is corrected by adding 3 only when its value is greater than 4, and no correction follows the final shift. Small inputs such as 5, 9 and 10 therefore come out unchanged in decimal form, not offset by 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request. Captures `bin_i` when the block is not busy |
| bin_i | input | IN_W | Unsigned binary value to convert |
| bcd_o | output | 4*NDIG | Held packed decimal result, digit 0 in the low nibble |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest condition to reach from the ports is a start strobe that arrives at a precise point: in the middle of a running conversion, or exactly in the single cycle when the completion pulse is high. Both must be driven at a known cycle offset from the accepting edge. The bench counts edges from each accepted start and places strobes at chosen offsets and on the completion cycle itself. It also checks every 8-bit input exhaustively against a divide/modulo reference, with random gaps between requests.

// File: rtl/bcd_seq_pkg.sv
package bcd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SHIFT     = 3'd1,
    ST_CHK_SHIFT = 3'd2,
    ST_ADJ       = 3'd3,
    ST_CHK_DIG   = 3'd4,
    ST_DONE      = 3'd5
  } conv_state_t;

endpackage

// File: rtl/bcd_add3_cell.sv
// Single-digit correction: values above four get three added.
module bcd_add3_cell (
  input  logic [3:0] dig_i,
  output logic [3:0] dig_o
);
  always_comb begin
    if (dig_i > 4'd4) dig_o = dig_i + 4'd3;
    else              dig_o = dig_i;
  end
endmodule

// File: rtl/bcd_digit_pick.sv
// Selects one 4-bit digit by index with a per-digit multiplexer.
module bcd_digit_pick #(
  parameter int NDIG  = 3,
  parameter int IDX_W = 2
) (
  input  logic [4*NDIG-1:0] vec_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [3:0]        dig_o
);
  logic [3:0] slice [NDIG];

  for (genvar g = 0; g < NDIG; g++) begin : g_slice
    assign slice[g] = vec_i[4*g +: 4];
  end

  always_comb begin
    dig_o = '0;
    for (int k = 0; k < NDIG; k++) begin
      if (idx_i == IDX_W'(k)) dig_o = slice[k];
    end
  end
endmodule

// File: rtl/bcd_digit_put.sv
// Replaces the digit at the given index, passes all others through.
module bcd_digit_put #(
  parameter int NDIG  = 3,
  parameter int IDX_W = 2
) (
  input  logic [4*NDIG-1:0] vec_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [3:0]        dig_i,
  output logic [4*NDIG-1:0] vec_o
);
  for (genvar g = 0; g < NDIG; g++) begin : g_put
    assign vec_o[4*g +: 4] = (idx_i == IDX_W'(g)) ? dig_i : vec_i[4*g +: 4];
  end
endmodule

// File: rtl/bcd_seq_conv.sv
module bcd_seq_conv
  import bcd_seq_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int NDIG = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IN_W-1:0]   bin_i,
  output logic [4*NDIG-1:0] bcd_o,
  output logic              done_o
);
  localparam int BW     = 4 * NDIG;
  localparam int BCNT_W = $clog2(IN_W + 1);
  localparam int IDX_W  = (NDIG > 1) ? $clog2(NDIG) : 1;

  conv_state_t       state_q;
  logic [IN_W-1:0]   bin_q;
  logic [BW-1:0]     work_q;
  logic [BCNT_W-1:0] bit_cnt_q;
  logic [IDX_W-1:0]  dig_idx_q;

  logic [3:0]        cur_dig;
  logic [3:0]        fix_dig;
  logic [BW-1:0]     work_fixed;

  bcd_digit_pick #(.NDIG(NDIG), .IDX_W(IDX_W)) u_pick (
    .vec_i (work_q),
    .idx_i (dig_idx_q),
    .dig_o (cur_dig)
  );

  bcd_add3_cell u_add3 (
    .dig_i (cur_dig),
    .dig_o (fix_dig)
  );

  bcd_digit_put #(.NDIG(NDIG), .IDX_W(IDX_W)) u_put (
    .vec_i (work_q),
    .idx_i (dig_idx_q),
    .dig_i (fix_dig),
    .vec_o (work_fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bin_q     <= '0;
      work_q    <= '0;
      bit_cnt_q <= '0;
      dig_idx_q <= '0;
      bcd_o     <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            bin_q     <= bin_i;
            work_q    <= '0;
            bit_cnt_q <= '0;
            state_q   <= ST_SHIFT;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          work_q    <= {work_q[BW-2:0], bin_q[IN_W-1]};
          bin_q     <= {bin_q[IN_W-2:0], 1'b0};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          state_q   <= ST_CHK_SHIFT;
        end
        ST_CHK_SHIFT: begin
          if (bit_cnt_q == BCNT_W'(IN_W)) begin
            bcd_o   <= work_q;
            done_o  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            dig_idx_q <= '0;
            state_q   <= ST_ADJ;
          end
        end
        ST_ADJ: begin
          work_q  <= work_fixed;
          state_q <= ST_CHK_DIG;
        end
        ST_CHK_DIG: begin
          if (dig_idx_q == IDX_W'(NDIG - 1)) begin
            state_q <= ST_SHIFT;
          end else begin
            dig_idx_q <= dig_idx_q + 1'b1;
            state_q   <= ST_ADJ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bcd_seq_conv_chk.sv
module bcd_seq_conv_chk #(
  parameter int IN_W = 8,
  parameter int NDIG = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [4*NDIG-1:0] bcd_o,
  input logic              done_o
);
  localparam int LAT   = 2 * IN_W + 2 * NDIG * (IN_W - 1);
  localparam int CNT_W = $clog2(LAT + 2);

  logic             busy_m = 1'b0;
  logic [CNT_W-1:0] cyc_m  = '0;
  logic             rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst) begin
      busy_m <= 1'b0;
      cyc_m  <= '0;
    end else if (start && (!busy_m || done_o)) begin
      busy_m <= 1'b1;
      cyc_m  <= '0;
    end else if (done_o) begin
      busy_m <= 1'b0;
    end else if (busy_m) begin
      cyc_m <= cyc_m + 1'b1;
    end
  end

  // R1
  always @(posedge clk) begin
    if (rst_seen) begin
      reset_state_chk: assert (bcd_o == '0 && !done_o)
        else $error("output not cleared after reset");
    end
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cyc_m == CNT_W'(LAT)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bcd_o) |-> done_o);

  // R6
  done_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_m);

endmodule

bind bcd_seq_conv bcd_seq_conv_chk #(.IN_W(IN_W), .NDIG(NDIG)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .bcd_o  (bcd_o),
  .done_o (done_o)
);

// File: tb/bcd_seq_conv_bench.sv
`timescale 1ns/1ps
module bcd_seq_conv_bench;
  localparam int IN_W = 8;
  localparam int NDIG = 3;
  localparam int BW   = 4 * NDIG;
  localparam int LAT  = 2 * IN_W + 2 * NDIG * (IN_W - 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [IN_W-1:0] bin_i = '0;
  logic [BW-1:0]   bcd_o;
  logic            done_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  bcd_seq_conv #(.IN_W(IN_W), .NDIG(NDIG)) u_bcd_seq_conv (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .bin_i  (bin_i),
    .bcd_o  (bcd_o),
    .done_o (done_o)
  );

  function automatic logic [BW-1:0] ref_bcd(input int v);
    logic [BW-1:0] r = '0;
    int t = v;
    for (int k = 0; k < NDIG; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all calls start and end at a negative edge
  task automatic go(input int v);
    start = 1'b1;
    bin_i = IN_W'(v);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (!done_o && n < 4 * LAT);
  endtask

  task automatic conv(input int v);
    int n;
    go(v);
    wait_done(n);
    chk(n == LAT, "R3 latency", n, LAT);
    chk(bcd_o == ref_bcd(v), "R2 value", int'(bcd_o), int'(ref_bcd(v)));
  endtask

  initial begin
    repeat (2000 * (LAT + 4)) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [BW-1:0] held;
    void'($urandom(32'h5EED));

    repeat (3) @(negedge clk);
    chk(bcd_o == '0 && !done_o, "R1 in reset", int'(bcd_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bcd_o == '0 && !done_o, "R1 after reset", int'(bcd_o), 0);

    // R8 directed: digits near the correction threshold
    conv(5);
    conv(9);
    conv(10);
    conv(0);
    conv((1 << IN_W) - 1);

    // R2 exhaustive
    for (int v = 0; v < (1 << IN_W); v++) conv(v);

    // R4 and R5: pulse width and hold while idle
    conv(173);
    held = bcd_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!done_o, "R4 single pulse", int'(done_o), 0);
      chk(bcd_o == held, "R5 hold", int'(bcd_o), int'(held));
    end

    // R6: start mid-conversion ignored
    go(47);
    repeat (11) @(negedge clk);
    go(201);
    wait_done(n);
    chk(n == LAT - 12, "R6 timing", n, LAT - 12);
    chk(bcd_o == ref_bcd(47), "R6 value", int'(bcd_o), int'(ref_bcd(47)));
    for (int i = 0; i < LAT + 4; i++) begin
      @(negedge clk);
      chk(!done_o, "R6 no extra done", int'(done_o), 0);
    end

    // R7: start in the done cycle
    go(88);
    wait_done(n);
    chk(n == LAT && bcd_o == ref_bcd(88), "R7 first", int'(bcd_o), int'(ref_bcd(88)));
    go(219);
    chk(!done_o, "R7 done dropped", int'(done_o), 0);
    wait_done(n);
    chk(n == LAT, "R7 latency", n, LAT);
    chk(bcd_o == ref_bcd(219), "R7 value", int'(bcd_o), int'(ref_bcd(219)));

    // random values with random idle gaps
    for (int i = 0; i < 200; i++) begin
      int v = int'($urandom % (1 << IN_W));
      repeat ($urandom % 4) @(negedge clk);
      conv(v);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule